// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Zero Suppression

This block turns BCD digits into seven-segment drive patterns for a six-digit numeric display. The display has a fixed decimal point between the integer group and the fraction group. Each digit position has its own decoder, which lights the pattern for 0 to 9. An optional parameter adds the hexadecimal glyphs A to F. A row of decoders is wired as a ripple chain, so that zeros carrying no information disappear from view.

In the integer group the ripple starts at the leftmost digit and travels right. In the fraction group it starts at the rightmost digit and travels left. The digit on each side of the point never takes part in suppression, so an all-zero value still reads "0.0". A lamp-test input lights every segment so that dead segments can be found. A blanking input darkens the whole display and wins over lamp test. One parameter selects active-high drive (common cathode) or active-low drive (common anode).

All outputs pass through one register stage, which has a synchronous active-high reset. The digit decoders, the ripple chains and the polarity selection are combinational.

Top module: `sevseg_display`

## Requirements
- R1: Digit k occupies `digits_i[4k+3:4k]`, where k=0 is the rightmost position. Its segments occupy `seg_o[7k+6:7k]`, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. Codes 0 to 9 give the usual decimal glyphs; for example, 6 lights a, c, d, e, f and g and leaves b dark.
- R2: With `HEX_EN`=0, codes 10 to 15 darken that digit. A nonzero code like this still stops zero suppression.
- R3: With `HEX_EN`=1, codes 10 to 15 show A, b, C, d, E and F.
- R4: A zero in the integer group is dark when every integer digit to its left is also zero. The integer digit next to the point is always shown.
- R5: A zero in the fraction group is dark when every fraction digit to its right is also zero. The fraction digit next to the point is always shown.
- R6: A nonzero digit stops suppression for the rest of its group. Zeros between significant digits stay visible, so the input 030.080 shows as 30.08.
- R7: While `lamp_test_n` is 0 and `blank` is 0, every segment and the point are lit, whatever the data is, including digits that would otherwise be suppressed.
- R8: While `blank` is 1, every segment and the point are dark, whether or not lamp test is active.
- R9: With `ACTIVE_LOW`=1, every output is inverted: lit is 0 and dark is 1.
- R10: The outputs show the inputs sampled at the previous rising clock edge and hold their value between edges. While `rst` is 1, the outputs are dark in the selected polarity.
- R11: `dp_o`, the fixed decimal point, is lit whenever `blank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high; forces a dark display |
| digits_i | input | 4*(INT_DIGITS+FRAC_DIGITS) | Packed BCD digits, rightmost digit in the low nibble |
| lamp_test_n | input | 1 | Lamp test, active low |
| blank | input | 1 | Display blanking, active high |
| seg_o | output | 7*(INT_DIGITS+FRAC_DIGITS) | Registered segment drive, seven bits per digit |
| dp_o | output | 1 | Registered drive for the fixed decimal point |

## Verification
Lamp test and blanking can be active in the same cycle. Lamp test can also coincide with a digit that ripple suppression would darken. The bench applies all four combinations of `lamp_test_n` and `blank` on an all-zero value and on a value with interior zeros. In each case it computes whether blanking wins, whether lamp test relights suppressed positions, and whether the point follows. Random vectors weighted towards zero then mix these controls with glyph decoding and suppression. Each vector is checked on an active-high decimal instance and on an active-low hexadecimal instance.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_DARK = '0;
    localparam seg_t SEG_ALL  = '1;

    // result of one digit position: its segments and the ripple towards the point
    typedef struct packed {
        seg_t seg;
        logic rb_out;
    } dig_out_t;

    // active-high glyph, bit 0 = a ... bit 6 = g
    function automatic seg_t glyph(input bcd_t code, input logic hex_en);
        seg_t s;
        case (code)
            4'd0:    s = 7'b0111111;
            4'd1:    s = 7'b0000110;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1001111;
            4'd4:    s = 7'b1100110;
            4'd5:    s = 7'b1101101;
            4'd6:    s = 7'b1111101;
            4'd7:    s = 7'b0000111;
            4'd8:    s = 7'b1111111;
            4'd9:    s = 7'b1101111;
            4'd10:   s = 7'b1110111;
            4'd11:   s = 7'b1111100;
            4'd12:   s = 7'b0111001;
            4'd13:   s = 7'b1011110;
            4'd14:   s = 7'b1111001;
            default: s = 7'b1110001;
        endcase
        if (!hex_en && code > 4'd9) begin
            s = SEG_DARK;
        end
        return s;
    endfunction

endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
    import sevseg_pkg::*;
#(
    parameter bit HEX_EN = 1'b0
) (
    input  bcd_t     digit_i,
    input  logic     lamp_on_i,
    input  logic     blank_i,
    input  logic     rb_in_i,
    output dig_out_t out_o
);

    logic is_zero;
    logic suppress;

    always_comb begin
        is_zero      = (digit_i == '0);
        suppress     = rb_in_i && is_zero;
        out_o.rb_out = suppress;
        if (blank_i) begin
            out_o.seg = SEG_DARK;
        end else if (lamp_on_i) begin
            out_o.seg = SEG_ALL;
        end else if (suppress) begin
            out_o.seg = SEG_DARK;
        end else begin
            out_o.seg = glyph(digit_i, HEX_EN);
        end
    end

endmodule

// File: rtl/seg_chain.sv
// Element 0 is the far end of a group; element N-1 sits next to the point.
module seg_chain
    import sevseg_pkg::*;
#(
    parameter int N      = 3,
    parameter bit HEX_EN = 1'b0
) (
    input  logic [N*BCD_W-1:0] digits_i,
    input  logic               lamp_on_i,
    input  logic               blank_i,
    output logic [N*SEG_W-1:0] segs_o
);

    logic [N:0]   rb;
    logic [N-1:0] rb_in;
    logic         unused_rb_tail;

    assign rb[0]          = 1'b1;
    assign unused_rb_tail = rb[N];

    for (genvar i = 0; i < N; i++) begin : g_dig
        dig_out_t d_out;

        if (i == N - 1) begin : g_anchor
            assign rb_in[i] = 1'b0;
        end else begin : g_link
            assign rb_in[i] = rb[i];
        end

        seg_digit_dec #(.HEX_EN(HEX_EN)) u_dec (
            .digit_i   (digits_i[i*BCD_W +: BCD_W]),
            .lamp_on_i (lamp_on_i),
            .blank_i   (blank_i),
            .rb_in_i   (rb_in[i]),
            .out_o     (d_out)
        );

        assign rb[i+1]                 = d_out.rb_out;
        assign segs_o[i*SEG_W +: SEG_W] = d_out.seg;
    end

endmodule

// File: rtl/sevseg_display.sv
module sevseg_display
    import sevseg_pkg::*;
#(
    parameter int INT_DIGITS  = 3,
    parameter int FRAC_DIGITS = 3,
    parameter bit HEX_EN      = 1'b0,
    parameter bit ACTIVE_LOW  = 1'b0,
    localparam int NUM_DIGITS = INT_DIGITS + FRAC_DIGITS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    input  logic                        lamp_test_n,
    input  logic                        blank,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_o,
    output logic                        dp_o
);

    localparam int SEGS_W = NUM_DIGITS * SEG_W;
    localparam logic [SEGS_W:0] DARK_BUS = {(SEGS_W + 1){ACTIVE_LOW}};

    logic                          lamp_on;
    logic                          dp_raw;
    logic [INT_DIGITS*BCD_W-1:0]   int_far;
    logic [INT_DIGITS*SEG_W-1:0]   int_seg_far;
    logic [FRAC_DIGITS*SEG_W-1:0]  frac_seg;
    logic [SEGS_W-1:0]             raw_seg;
    logic [SEGS_W:0]               drive_d;
    logic [SEGS_W:0]               drive_q;

    assign lamp_on = ~lamp_test_n;
    assign dp_raw  = ~blank;

    // integer group: leftmost digit is the far end of its chain
    for (genvar i = 0; i < INT_DIGITS; i++) begin : g_int_map
        assign int_far[i*BCD_W +: BCD_W] =
            digits_i[(NUM_DIGITS-1-i)*BCD_W +: BCD_W];
        assign raw_seg[(NUM_DIGITS-1-i)*SEG_W +: SEG_W] =
            int_seg_far[i*SEG_W +: SEG_W];
    end

    seg_chain #(.N(INT_DIGITS), .HEX_EN(HEX_EN)) u_int_chain (
        .digits_i  (int_far),
        .lamp_on_i (lamp_on),
        .blank_i   (blank),
        .segs_o    (int_seg_far)
    );

    // fraction group: rightmost digit is the far end, order already matches
    seg_chain #(.N(FRAC_DIGITS), .HEX_EN(HEX_EN)) u_frac_chain (
        .digits_i  (digits_i[FRAC_DIGITS*BCD_W-1:0]),
        .lamp_on_i (lamp_on),
        .blank_i   (blank),
        .segs_o    (frac_seg)
    );

    assign raw_seg[FRAC_DIGITS*SEG_W-1:0] = frac_seg;

    if (ACTIVE_LOW) begin : g_pol_low
        assign drive_d = ~{dp_raw, raw_seg};
    end else begin : g_pol_high
        assign drive_d = {dp_raw, raw_seg};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DARK_BUS;
        end else begin
            drive_q <= drive_d;
        end
    end

    assign {dp_o, seg_o} = drive_q;

endmodule

// File: rtl/sevseg_display_chk.sv
module sevseg_display_chk
    import sevseg_pkg::*;
#(
    parameter int INT_DIGITS  = 3,
    parameter int FRAC_DIGITS = 3,
    parameter bit HEX_EN      = 1'b0,
    parameter bit ACTIVE_LOW  = 1'b0,
    localparam int NUM_DIGITS = INT_DIGITS + FRAC_DIGITS
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    input logic                        lamp_test_n,
    input logic                        blank,
    input logic [NUM_DIGITS*SEG_W-1:0] seg_o,
    input logic                        dp_o
);

    localparam int SEGS_W = NUM_DIGITS * SEG_W;
    localparam logic [SEGS_W-1:0] DARK = {SEGS_W{ACTIVE_LOW}};
    localparam logic [SEGS_W-1:0] LIT  = {SEGS_W{~ACTIVE_LOW}};
    localparam seg_t DIG_DARK = {SEG_W{ACTIVE_LOW}};

    // R10
    reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seg_o == DARK && dp_o == ACTIVE_LOW));

    // R8
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $past(blank) |-> (seg_o == DARK && dp_o == ACTIVE_LOW));

    // R7
    lamp_lit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!lamp_test_n && !blank && !rst) |-> (seg_o == LIT && dp_o == !ACTIVE_LOW));

    // R11
    point_lit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!blank && !rst) |-> (dp_o == !ACTIVE_LOW));

    if (INT_DIGITS > 1) begin : g_lead
        // R4
        lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $past(digits_i[(NUM_DIGITS-1)*BCD_W +: BCD_W] == '0 && lamp_test_n)
            |-> (seg_o[(NUM_DIGITS-1)*SEG_W +: SEG_W] == DIG_DARK));
    end

    if (FRAC_DIGITS > 1) begin : g_trail
        // R5
        trail_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $past(digits_i[BCD_W-1:0] == '0 && lamp_test_n)
            |-> (seg_o[SEG_W-1:0] == DIG_DARK));
    end

    if (!HEX_EN) begin : g_bad_code
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_pos
            // R2
            bad_code_dark_chk: assert property (@(posedge clk) disable iff (rst)
                $past(digits_i[k*BCD_W +: BCD_W] > 4'd9 && lamp_test_n)
                |-> (seg_o[k*SEG_W +: SEG_W] == DIG_DARK));
        end
    end

endmodule

bind sevseg_display sevseg_display_chk #(
    .INT_DIGITS  (INT_DIGITS),
    .FRAC_DIGITS (FRAC_DIGITS),
    .HEX_EN      (HEX_EN),
    .ACTIVE_LOW  (ACTIVE_LOW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .digits_i    (digits_i),
    .lamp_test_n (lamp_test_n),
    .blank       (blank),
    .seg_o       (seg_o),
    .dp_o        (dp_o)
);

// File: tb/test_sevseg_display.sv
`timescale 1ns/1ps
module test_sevseg_display;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] digits;
    logic        lt_n;
    logic        bl;
    logic [41:0] seg_a, seg_b;
    logic        dp_a, dp_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [42:0] exp_a, exp_b;

    always #4 clk = ~clk;

    sevseg_display i_sevseg_display (
        .clk(clk), .rst(rst), .digits_i(digits), .lamp_test_n(lt_n),
        .blank(bl), .seg_o(seg_a), .dp_o(dp_a)
    );

    sevseg_display #(.HEX_EN(1'b1), .ACTIVE_LOW(1'b1)) i_sevseg_display_hex (
        .clk(clk), .rst(rst), .digits_i(digits), .lamp_test_n(lt_n),
        .blank(bl), .seg_o(seg_b), .dp_o(dp_b)
    );

    function automatic logic [6:0] letters(input string s);
        logic [6:0] r = '0;
        for (int i = 0; i < s.len(); i++) r[int'(s[i]) - 97] = 1'b1;
        return r;
    endfunction

    function automatic logic [6:0] glyph_ref(input int v, input bit hex);
        string s;
        case (v)
            0: s = "abcdef";   1: s = "bc";      2: s = "abdeg";   3: s = "abcdg";
            4: s = "bcfg";     5: s = "acdfg";   6: s = "acdefg";  7: s = "abc";
            8: s = "abcdefg";  9: s = "abcdfg";  10: s = "abcefg"; 11: s = "cdefg";
            12: s = "adef";    13: s = "bcdeg";  14: s = "adefg";  default: s = "aefg";
        endcase
        if (v > 9 && !hex) return 7'd0;
        return letters(s);
    endfunction

    function automatic logic [42:0] model(input logic [23:0] dg, input logic l,
                                          input logic b, input bit hex, input bit alow);
        logic [42:0] r;
        bit run;
        if (b) r = '0;
        else if (!l) r = '1;
        else begin
            r[42] = 1'b1;
            run = 1'b1;
            for (int k = 5; k >= 3; k--) begin
                int v;
                v = int'(dg[k*4 +: 4]);
                run = run && (v == 0);
                r[k*7 +: 7] = (run && k != 3) ? 7'd0 : glyph_ref(v, hex);
            end
            run = 1'b1;
            for (int k = 0; k <= 2; k++) begin
                int v;
                v = int'(dg[k*4 +: 4]);
                run = run && (v == 0);
                r[k*7 +: 7] = (run && k != 2) ? 7'd0 : glyph_ref(v, hex);
            end
        end
        if (alow) r = ~r;
        return r;
    endfunction

    task automatic check(input logic [42:0] got, input logic [42:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [23:0] dg, input logic l, input logic b, input string tag);
        @(negedge clk);
        digits = dg; lt_n = l; bl = b;
        #1;
        check({dp_a, seg_a}, exp_a, "R10 hold before edge");
        check({dp_b, seg_b}, exp_b, "R10 R9 hold before edge");
        @(negedge clk);
        exp_a = model(dg, l, b, 1'b0, 1'b0);
        exp_b = model(dg, l, b, 1'b1, 1'b1);
        check({dp_a, seg_a}, exp_a, tag);
        check({dp_b, seg_b}, exp_b, {tag, " R9"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; digits = 24'h123456; lt_n = 1'b0; bl = 1'b0;
        exp_a = '0; exp_b = '1;
        repeat (3) begin
            @(negedge clk);
            check({dp_a, seg_a}, exp_a, "R10 reset dark");
            check({dp_b, seg_b}, exp_b, "R10 R9 reset dark");
        end
        @(negedge clk);
        bl = 1'b1; rst = 1'b0;

        // R1 digit six alone in a fraction slot
        step(24'h000060, 1'b1, 1'b0, "R1 digit six");
        check({25'd0, seg_a[13:7]}, {25'd0, letters("acdefg")}, "R1 six glyph");

        // R1 R2 R3 glyphs with no suppression around them
        for (int p = 0; p < 6; p++)
            for (int v = 0; v < 16; v++) begin
                logic [23:0] dg = 24'h888888;
                dg[p*4 +: 4] = v[3:0];
                step(dg, 1'b1, 1'b0, "R1 R2 R3 glyph sweep");
            end

        // R4 R5 suppression with a single digit set
        for (int p = 0; p < 6; p++)
            for (int v = 0; v < 16; v++) begin
                logic [23:0] dg = 24'h000000;
                dg[p*4 +: 4] = v[3:0];
                step(dg, 1'b1, 1'b0, "R4 R5 R2 suppression sweep");
            end

        step(24'h030080, 1'b1, 1'b0, "R6 inner zeros 30.08");
        step(24'h000000, 1'b1, 1'b0, "R4 R5 anchors 0.0");
        step(24'h100001, 1'b1, 1'b0, "R6 interior zeros kept");

        // R7 R8 R11 control overlap
        for (int c = 0; c < 4; c++) begin
            step(24'h000000, c[0], c[1], "R7 R8 R11 controls zeros");
            step(24'h905030, c[0], c[1], "R7 R8 R11 controls data");
        end

        // mixed random vectors weighted towards zero
        for (int n = 0; n < 800; n++) begin
            logic [23:0] dg;
            for (int k = 0; k < 6; k++)
                dg[k*4 +: 4] = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            step(dg, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
                 "R4 R5 R6 R7 R8 R11 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule